// File: doc/BRIEF.md
# Interval Timer Counter Channel

This block is one 16-bit down-counting channel of an interval timer, meant to drive an interrupt request line. Software first writes a control word that selects one of two behaviours, then writes a count value. After a one-shot setup the output rises once when the count runs out. In the periodic behaviour the output drops for one tick in every period. The count only advances on system clocks where the clock-enable input is high, so the input clock can be divided down to any tick rate.

In the periodic behaviour the gate input can hold the count or restart it. A new count written while a period is running is kept until that period ends. A control-word write stops the channel at once and sets the output to a known level.

Top module: `pit_channel`

## Requirements
- R1: After reset the channel uses the one-shot behaviour, does not count, and drives `tmr_out` low until a count is written.
- R2: A control-word write (`ctl_we`) stops any count in progress and clears any pending load. On the next clock `tmr_out` is low for `ctl_mode`=0 (one-shot) and high for `ctl_mode`=1 (periodic). It stays at that level until a count is written.
- R3: A written count is loaded on the first enabled clock (`ce`=1) after the write. Each later enabled clock decrements it by one. While `ce` is low the count holds and `tmr_out` does not change.
- R4: One-shot: a count write drives `tmr_out` low on the next clock. `tmr_out` rises after N+1 enabled clocks (one load plus N decrements) and stays high. The channel does not restart by itself.
- R5: One-shot: a count write while counting stops the old count. The new value is loaded and the full N+1 delay runs again from that write.
- R6: Periodic with a count N from 2 to 65536: the first low pulse on `tmr_out` comes N enabled clocks after the write clock. After that `tmr_out` is low for exactly one enabled clock in every N.
- R7: Periodic: a count written while a period is running does not change that period. The new value is used from the next reload.
- R8: Periodic: while `gate` is low the count holds and `tmr_out` is high on the next clock.
- R9: Periodic: a rising edge on `gate` reloads the most recently written count on that enabled clock. The period starts again from that clock.
- R10: A written count of 0 counts as 65536. In one-shot it raises `tmr_out` 65537 enabled clocks after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce | input | 1 | Count tick enable |
| gate | input | 1 | Hold (low) and restart (rising edge) for the periodic behaviour |
| ctl_we | input | 1 | Control-word write strobe |
| ctl_mode | input | 1 | Behaviour select: 0 one-shot, 1 periodic |
| cnt_we | input | 1 | Count-value write strobe |
| cnt_din | input | 16 | Count value (0 means 65536) |
| tmr_out | output | 1 | Timer output to the interrupt controller |

## Verification
A wrong count, a lost reload or a stuck pending load only shows at `tmr_out`. The error appears as an edge in the wrong place, often a full period after the fault. For that reason, checks sample the output one clock before, at, and one clock after each expected edge. A reload that uses a stale value, or a retrigger that ignores the newest count, shows up only on the first pulse after the event. The stall and retrigger scenarios are set so that the correct and the faulty pulse positions differ by at least two clocks.

// File: rtl/pit_pkg.sv
package pit_pkg;

  // Behaviour selected by the control word
  typedef enum logic {
    PIT_MODE_ONESHOT = 1'b0,
    PIT_MODE_RATE    = 1'b1
  } pit_mode_e;

endpackage

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         ce,
  input  logic         gate,
  input  logic         ctl_we,
  input  logic         ctl_mode,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_din,
  input  logic         run,
  output pit_mode_e    mode_q,
  output logic [W-1:0] preset_q,
  output logic         fire,
  output logic         wr_stop,
  output logic         retrig
);

  logic      valid_q, valid_n;
  logic      pend_q, pend_n;
  logic      gate_q;
  logic      hold;
  pit_mode_e mode_n;
  logic [W-1:0] preset_n;

  always_comb begin
    retrig  = (mode_q == PIT_MODE_RATE) && gate && !gate_q && valid_q && !ctl_we;
    hold    = cnt_we && !ctl_we && ((mode_q == PIT_MODE_ONESHOT) || !run);
    wr_stop = cnt_we && !ctl_we && (mode_q == PIT_MODE_ONESHOT);
    fire    = ce && !ctl_we && !hold && (pend_q || retrig);

    mode_n   = ctl_we ? pit_mode_e'(ctl_mode) : mode_q;
    preset_n = (cnt_we && !ctl_we) ? cnt_din : preset_q;

    if (ctl_we)      valid_n = 1'b0;
    else if (cnt_we) valid_n = 1'b1;
    else             valid_n = valid_q;

    if (ctl_we)      pend_n = 1'b0;
    else if (hold)   pend_n = 1'b1;
    else if (fire)   pend_n = 1'b0;
    else if (retrig) pend_n = 1'b1;
    else             pend_n = pend_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= PIT_MODE_ONESHOT;
      preset_q <= '0;
      valid_q  <= 1'b0;
      pend_q   <= 1'b0;
      gate_q   <= 1'b0;
    end else begin
      mode_q   <= mode_n;
      preset_q <= preset_n;
      valid_q  <= valid_n;
      pend_q   <= pend_n;
      gate_q   <= gate;
    end
  end

  // R3
  pend_done_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (pend_q && ce && !ctl_we && !hold) |=> !pend_q);

  // R2
  ctl_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ctl_we |=> (!pend_q && !valid_q));

endmodule

// File: rtl/pit_down.sv
module pit_down
  import pit_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         ce,
  input  logic         gate,
  input  logic         clr,
  input  logic         stop,
  input  logic         fire,
  input  pit_mode_e    mode,
  input  logic [W-1:0] preset,
  output logic [W-1:0] cnt_q,
  output logic         run_q,
  output logic [W-1:0] cnt_n,
  output logic         run_n,
  output logic         ev_tc
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic step;
  logic cnt_en;

  always_comb begin
    step  = run_q && ce && !clr && !stop && !fire &&
            ((mode == PIT_MODE_ONESHOT) || gate);
    ev_tc = step && (mode == PIT_MODE_ONESHOT) && (cnt_q == ONE);

    cnt_n = cnt_q;
    run_n = run_q;
    if (clr || stop) begin
      run_n = 1'b0;
    end else if (fire) begin
      cnt_n = preset;
      run_n = 1'b1;
    end else if (step) begin
      if ((mode == PIT_MODE_RATE) && (cnt_q == ONE)) cnt_n = preset;
      else                                           cnt_n = cnt_q - ONE;
      if (ev_tc) run_n = 1'b0;
    end
    cnt_en = fire || step;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_n;
      run_q <= run_n;
    end
  end

  // R3
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !ce |=> $stable(cnt_q));

  // R4
  tc_halt_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ev_tc |=> (!run_q && (cnt_q == '0)));

endmodule

// File: rtl/pit_wave.sv
module pit_wave
  import pit_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         ce,
  input  logic         gate,
  input  logic         ctl_we,
  input  logic         ctl_mode,
  input  pit_mode_e    mode,
  input  logic         stop,
  input  logic         ev_tc,
  input  logic         run_n,
  input  logic [W-1:0] cnt_n,
  input  logic [W-1:0] preset,
  output logic         out_q
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic out_n;

  always_comb begin
    if (ctl_we) begin
      out_n = ctl_mode;
    end else if (mode == PIT_MODE_ONESHOT) begin
      if (stop)       out_n = 1'b0;
      else if (ev_tc) out_n = 1'b1;
      else            out_n = out_q;
    end else begin
      if (!gate) out_n = 1'b1;
      else       out_n = !(run_n && (cnt_n == ONE));
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else         out_q <= out_n;
  end

  // R6
  rate_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode == PIT_MODE_RATE && !out_q && ce && !ctl_we && preset != ONE) |=> out_q);

  // R8
  gate_force_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode == PIT_MODE_RATE && !gate && !ctl_we) |=> out_q);

  // R4
  hold_high_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode == PIT_MODE_ONESHOT && out_q && !stop && !ctl_we) |=> out_q);

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             gate,
  input  logic             ctl_we,
  input  logic             ctl_mode,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_din,
  output logic             tmr_out
);

  logic [1:0]       rst_sync_q;
  logic             rst_ni;
  pit_mode_e        mode_q;
  logic [CNT_W-1:0] preset_q;
  logic             fire, wr_stop, retrig;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             run_q, run_n, ev_tc;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  pit_ctrl #(.W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .ce       (ce),
    .gate     (gate),
    .ctl_we   (ctl_we),
    .ctl_mode (ctl_mode),
    .cnt_we   (cnt_we),
    .cnt_din  (cnt_din),
    .run      (run_q),
    .mode_q   (mode_q),
    .preset_q (preset_q),
    .fire     (fire),
    .wr_stop  (wr_stop),
    .retrig   (retrig)
  );

  pit_down #(.W(CNT_W)) u_down (
    .clk    (clk),
    .rst_ni (rst_ni),
    .ce     (ce),
    .gate   (gate),
    .clr    (ctl_we),
    .stop   (wr_stop),
    .fire   (fire),
    .mode   (mode_q),
    .preset (preset_q),
    .cnt_q  (cnt_q),
    .run_q  (run_q),
    .cnt_n  (cnt_n),
    .run_n  (run_n),
    .ev_tc  (ev_tc)
  );

  pit_wave #(.W(CNT_W)) u_wave (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .ce       (ce),
    .gate     (gate),
    .ctl_we   (ctl_we),
    .ctl_mode (ctl_mode),
    .mode     (mode_q),
    .stop     (wr_stop),
    .ev_tc    (ev_tc),
    .run_n    (run_n),
    .cnt_n    (cnt_n),
    .preset   (preset_q),
    .out_q    (tmr_out)
  );

  // R2
  ctl_out_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ctl_we |=> (tmr_out == $past(ctl_mode)));

  // R9
  retrig_load_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (retrig && fire) |=> (cnt_q == $past(preset_q) && run_q));

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_q == PIT_MODE_ONESHOT && !run_q && !ev_tc && !tmr_out && !ctl_we) |=> !tmr_out);

endmodule

// File: tb/test_pit_channel.sv
module test_pit_channel;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce, gate, ctl_we, ctl_mode, cnt_we;
  logic [15:0] cnt_din;
  logic        tmr_out;

  int n_cmp  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pit_channel i_pit_channel (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce       (ce),
    .gate     (gate),
    .ctl_we   (ctl_we),
    .ctl_mode (ctl_mode),
    .cnt_we   (cnt_we),
    .cnt_din  (cnt_din),
    .tmr_out  (tmr_out)
  );

  // {mode, count, clocks after write edge, expected out}
  localparam int NV = 13;
  localparam logic [34:0] VEC [NV] = '{
    {1'b0, 16'd5, 17'd5,  1'b0},
    {1'b0, 16'd5, 17'd6,  1'b1},
    {1'b0, 16'd5, 17'd20, 1'b1},
    {1'b0, 16'd1, 17'd1,  1'b0},
    {1'b0, 16'd1, 17'd2,  1'b1},
    {1'b1, 16'd4, 17'd3,  1'b1},
    {1'b1, 16'd4, 17'd4,  1'b0},
    {1'b1, 16'd4, 17'd5,  1'b1},
    {1'b1, 16'd4, 17'd8,  1'b0},
    {1'b1, 16'd2, 17'd2,  1'b0},
    {1'b1, 16'd2, 17'd3,  1'b1},
    {1'b1, 16'd2, 17'd6,  1'b0},
    {1'b1, 16'd3, 17'd0,  1'b1}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctl(input logic m);
    ctl_we = 1'b1; ctl_mode = m;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic wr_cnt(input logic [15:0] v);
    cnt_we = 1'b1; cnt_din = v;
    @(negedge clk);
    cnt_we = 1'b0;
  endtask

  task automatic check(input logic exp, input string tag);
    n_cmp++;
    if (tmr_out !== exp) begin
      n_fail++;
      $display("FAIL %s: tmr_out=%b expected=%b at %0t", tag, tmr_out, exp, $time);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run=unfinished expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ce = 1'b1; gate = 1'b1;
    ctl_we = 1'b0; ctl_mode = 1'b0; cnt_we = 1'b0; cnt_din = '0;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    check(1'b0, "R1 reset level");
    tick(10);
    check(1'b0, "R1 idle without count");

    for (int i = 0; i < NV; i++) begin
      wr_ctl(VEC[i][34]);
      wr_cnt(VEC[i][33:18]);
      tick(int'(VEC[i][17:1]));
      check(VEC[i][0], VEC[i][34] ? "R6 periodic table" : "R4 one-shot table");
    end

    // R2: control write stops a running count
    wr_ctl(1'b1); wr_cnt(16'd10); tick(3);
    wr_ctl(1'b0);
    check(1'b0, "R2 one-shot level");
    tick(20);
    check(1'b0, "R2 stays low");
    wr_ctl(1'b1);
    check(1'b1, "R2 periodic level");
    tick(20);
    check(1'b1, "R2 stays high");

    // R5: one-shot rewrite restarts
    wr_ctl(1'b0); wr_cnt(16'd5); tick(3);
    wr_cnt(16'd4);
    tick(4);
    check(1'b0, "R5 before new terminal");
    tick(1);
    check(1'b1, "R5 new terminal");
    wr_cnt(16'd3);
    check(1'b0, "R4 low on rewrite");

    // R7: periodic new count deferred
    wr_ctl(1'b1); wr_cnt(16'd6); tick(2);
    wr_cnt(16'd3);
    tick(2);
    check(1'b1, "R7 before old end");
    tick(1);
    check(1'b0, "R7 old period kept");
    tick(1);
    check(1'b1, "R7 after reload");
    tick(1);
    check(1'b1, "R7 new period mid");
    tick(1);
    check(1'b0, "R7 new period end");

    // R8 then R9: gate hold and retrigger
    wr_ctl(1'b1); wr_cnt(16'd3); tick(2);
    gate = 1'b0;
    tick(1);
    check(1'b1, "R8 gate forces high");
    tick(2);
    check(1'b1, "R8 held");
    gate = 1'b1;
    tick(2);
    check(1'b1, "R9 restarted count");
    tick(1);
    check(1'b0, "R9 pulse after retrigger");

    // R9: retrigger uses the newest count
    wr_ctl(1'b1); wr_cnt(16'd8); tick(2);
    wr_cnt(16'd4);
    gate = 1'b0;
    tick(1);
    gate = 1'b1;
    tick(3);
    check(1'b1, "R9 newest count mid");
    tick(1);
    check(1'b0, "R9 newest count end");

    // R3: clock enable
    wr_ctl(1'b0);
    ce = 1'b0;
    wr_cnt(16'd3);
    tick(10);
    check(1'b0, "R3 no count without ce");
    ce = 1'b1;
    tick(3);
    check(1'b0, "R3 before terminal");
    tick(1);
    check(1'b1, "R3 terminal after ce ticks");

    // R10: zero means 65536
    wr_ctl(1'b0); wr_cnt(16'd0);
    tick(65536);
    check(1'b0, "R10 before terminal");
    tick(1);
    check(1'b1, "R10 terminal");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

endmodule